// File: doc/BRIEF.md
# Hiccup-Mode Retry Sequencer

This block decides when the power stage of a buck converter may switch after an overcurrent event. While it runs normally the gates stay enabled. The first qualified trip, meaning one that arrives while the gates are enabled, turns both gates off on the next clock. The block then enters an endless retry loop. First come two cooling intervals with the gates off. Each interval is as long as a full soft-start. After them the block requests a real soft-start ramp.

If a trip arrives during that ramp, the output shuts off again and the loop restarts at the first cooling interval. When the external ramp generator reports completion, the converter returns to normal operation. No trip counter or permanent latch exists, so retries never stop. One retry period is two fixed cooling intervals plus a ramp portion whose length depends on how soon the trip comes.

All pins are plain level control signals. There is no data stream, so no valid/ready handshake is used. The ramp generator itself sits outside this block. The block only requests a ramp (`ss_run`) and listens for its completion (`ss_done`).

Top module: `hiccup_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `phase` is 0 (idle), and `gate_en` and `ss_run` are both 0. Reset is asynchronous and returns the block to idle from any state.
- R2: In idle with `enable` high at a clock edge, the next cycle shows `phase`=1 (ramp), `gate_en`=1 and `ss_run`=1.
- R3: In ramp, `ss_done` high without `trip` at an edge moves the block to `phase`=2 (normal): `gate_en`=1, `ss_run`=0.
- R4: A `trip` sampled in ramp or normal gives `phase`=3 (first cooling interval) on the next cycle, with `gate_en`=0 and `ss_run`=0.
- R5: The first cooling interval (`phase`=3) lasts exactly SS_CYCLES clock cycles. It is followed by the second cooling interval (`phase`=4), which also lasts SS_CYCLES cycles. Ramp (`phase`=1) then follows. The gates stay off throughout.
- R6: `trip` and `ss_done` have no effect in idle or in either cooling interval.
- R7: When `trip` and `ss_done` are both high in the same ramp cycle, the trip wins and the block goes to `phase`=3.
- R8: `enable` low at a clock edge returns the block to idle (`phase`=0, gates off) from any state. This takes priority over every other input.
- R9: Retries are unlimited. After any number of consecutive trips, the block still re-enters ramp after the two cooling intervals.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; low forces idle |
| trip | input | 1 | Overcurrent trip indication, sampled each clock |
| ss_done | input | 1 | Soft-start ramp completion from the ramp generator |
| gate_en | output | 1 | Allows both high-side and low-side gates to switch |
| ss_run | output | 1 | Requests the ramp generator to run a soft-start |
| phase | output | 3 | 0 idle, 1 ramp, 2 normal, 3 first cooling, 4 second cooling |

## Verification
The assertions assume that `trip` and `ss_done` are clean synchronous levels sampled at each rising edge. They also assume that `enable` may change in any cycle, so every property that follows a state forward is qualified by `enable` being high. The cooling-length properties also assume that the cooling counter in the checker starts at zero on entry to `phase`=3. That holds because the only way into that phase is a trip from ramp or normal.

The stimulus drives all inputs on the falling edge. It keeps `enable` high most of the time so that long cooling and retry sequences complete. It also raises `trip` and `ss_done` in every state, including the cooling intervals where they must be ignored.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_RAMP  = 3'd1,
    PH_RUN   = 3'd2,
    PH_COOL1 = 3'd3,
    PH_COOL2 = 3'd4
  } phase_t;
endpackage

// File: rtl/hiccup_cool_timer.sv
module hiccup_cool_timer #(
  parameter int SS_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = $clog2(SS_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SS_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign expire = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run || expire)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hiccup_fsm.sv
module hiccup_fsm
  import hiccup_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enable,
  input  logic   trip,
  input  logic   ss_done,
  input  logic   cool_expire,
  output phase_t state
);
  phase_t nxt;

  always_comb begin
    nxt = state;
    if (!enable) begin
      nxt = PH_IDLE;
    end else begin
      unique case (state)
        PH_IDLE:  nxt = PH_RAMP;
        PH_RAMP:  if (trip) nxt = PH_COOL1;
                  else if (ss_done) nxt = PH_RUN;
        PH_RUN:   if (trip) nxt = PH_COOL1;
        PH_COOL1: if (cool_expire) nxt = PH_COOL2;
        PH_COOL2: if (cool_expire) nxt = PH_RAMP;
        default:  nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PH_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/hiccup_out_decode.sv
module hiccup_out_decode
  import hiccup_pkg::*;
(
  input  phase_t     state,
  output logic       gate_en,
  output logic       ss_run,
  output logic       cool,
  output logic [2:0] phase
);
  always_comb begin
    gate_en = (state == PH_RAMP) || (state == PH_RUN);
    ss_run  = (state == PH_RAMP);
    cool    = (state == PH_COOL1) || (state == PH_COOL2);
    phase   = 3'(state);
  end
endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq
  import hiccup_pkg::*;
#(
  parameter int SS_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       trip,
  input  logic       ss_done,
  output logic       gate_en,
  output logic       ss_run,
  output logic [2:0] phase
);
  phase_t state;
  logic   cool;
  logic   cool_expire;

  hiccup_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .trip        (trip),
    .ss_done     (ss_done),
    .cool_expire (cool_expire),
    .state       (state)
  );

  hiccup_cool_timer #(.SS_CYCLES(SS_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (cool),
    .expire (cool_expire)
  );

  hiccup_out_decode u_dec (
    .state   (state),
    .gate_en (gate_en),
    .ss_run  (ss_run),
    .cool    (cool),
    .phase   (phase)
  );
endmodule

// File: rtl/hiccup_seq_chk.sv
module hiccup_seq_chk #(
  parameter int SS_CYCLES = 1000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       trip,
  input logic       ss_done,
  input logic       gate_en,
  input logic       ss_run,
  input logic [2:0] phase
);
  int unsigned ccnt;
  logic        last;

  assign last = (ccnt == SS_CYCLES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ccnt <= 0;
    else if ((phase == 3'd3 || phase == 3'd4) && enable)
      ccnt <= last ? 0 : ccnt + 1;
    else
      ccnt <= 0;
  end

  a_r2_start_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0 && enable) |=> (phase == 3'd1 && gate_en && ss_run));

  a_r3_done_run: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 && enable && !trip && ss_done) |=> (phase == 3'd2 && gate_en && !ss_run));

  a_r4_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && trip) |=> !gate_en);

  a_r5_cool_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3 && enable && !last) |=> phase == 3'd3);

  a_r5_cool_step: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3 && enable && last) |=> phase == 3'd4);

  a_r9_retry_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4 && enable && last) |=> phase == 3'd1);

  a_r5_cool_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3 || phase == 3'd4) |-> (!gate_en && !ss_run));

  a_r7_trip_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 && enable && trip && ss_done) |=> phase == 3'd3);

  a_r8_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (phase == 3'd0 && !gate_en));
endmodule

bind hiccup_seq hiccup_seq_chk #(.SS_CYCLES(SS_CYCLES)) u_chk (.*);

// File: tb/test_hiccup_seq.sv
`timescale 1ns/1ps
module test_hiccup_seq;
  localparam int N = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       trip = 1'b0;
  logic       ss_done = 1'b0;
  logic       gate_en;
  logic       ss_run;
  logic [2:0] phase;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  int m_ph = 0;
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  hiccup_seq #(.SS_CYCLES(N)) i_hiccup_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .trip(trip),
    .ss_done(ss_done), .gate_en(gate_en), .ss_run(ss_run), .phase(phase)
  );

  function automatic int next_ph(int ph, int cnt, bit en, bit tr, bit dn);
    if (!en) return 0;
    case (ph)
      0: return 1;
      1: return tr ? 3 : (dn ? 2 : 1);
      2: return tr ? 3 : 2;
      3: return (cnt == N - 1) ? 4 : 3;
      4: return (cnt == N - 1) ? 1 : 4;
      default: return 0;
    endcase
  endfunction

  function automatic int next_cnt(int ph, int cnt, bit en);
    if (!en || (ph != 3 && ph != 4) || cnt == N - 1) return 0;
    return cnt + 1;
  endfunction

  task automatic check(string tag);
    bit exp_g, exp_s;
    exp_g = (m_ph == 1 || m_ph == 2);
    exp_s = (m_ph == 1);
    n_chk++;
    if (phase !== 3'(m_ph) || gate_en !== exp_g || ss_run !== exp_s) begin
      n_bad++;
      $display("FAIL %s: phase/gate/ss actual %0d/%0b/%0b expected %0d/%0b/%0b",
               tag, phase, gate_en, ss_run, m_ph, exp_g, exp_s);
    end
  endtask

  task automatic step(bit en, bit tr, bit dn, string tag);
    int np;
    enable = en; trip = tr; ss_done = dn;
    np = next_ph(m_ph, m_cnt, en, tr, dn);
    m_cnt = next_cnt(m_ph, m_cnt, en);
    if (np != m_ph && (np == 3)) m_cnt = 0;
    m_ph = np;
    @(negedge clk);
    check(tag);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    m_ph = 0; m_cnt = 0;
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset");

    step(1, 0, 0, "R2 enable to ramp");
    step(1, 0, 0, "R2 ramp holds");
    step(1, 0, 1, "R3 done to normal");
    step(1, 0, 0, "R3 normal holds");
    step(1, 1, 0, "R4 trip in normal");
    for (int i = 0; i < 2 * N; i++)
      step(1, i[0], ~i[0], "R5 R6 cooling with noise");
    step(1, 1, 1, "R7 trip beats done");
    for (int i = 0; i < 2 * N; i++) step(1, 0, 0, "R5 cooling again");
    step(1, 0, 0, "R4 ramp holds");
    step(1, 1, 0, "R4 trip in ramp");

    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 2 * N; i++) step(1, 0, 0, "R9 retry cooling");
      step(1, 1, 0, "R9 retry ramp then trip");
    end
    step(0, 1, 1, "R8 disable from cooling");
    step(0, 0, 0, "R6 idle stays disabled");
    step(1, 0, 0, "R2 restart");
    step(0, 0, 1, "R8 disable from ramp");

    for (int i = 0; i < 4000; i++) begin
      bit en, tr, dn;
      seed = $urandom;
      en = (seed % 100) < 97;
      tr = ((seed >> 8) % 100) < 8;
      dn = ((seed >> 16) % 100) < 15;
      step(en, tr, dn, "R2 R3 R4 R5 R6 R7 R8 random");
    end

    step(1, 0, 0, "R2 prep");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    m_ph = 0; m_cnt = 0;
    n_chk++;
    if (phase !== 3'd0 || gate_en !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 async reset: phase %0d expected 0", phase);
    end
    finish_run();
  end
endmodule